// File: doc/BRIEF.md
# SIMD Booth Multiplier Built From Two 16x8 Units

This block is a purely combinational 16-bit integer multiplier with two operating modes.

- **Wide mode** forms one 16x16 product with a 32-bit result.
- **Dual mode** splits both operands into bytes and forms two separate 8x8 products, one per 16-bit half of the result.

Each mode works on either two's-complement or unsigned data, selected by one input.

The datapath holds two identical 16x8 sub-multipliers. Each one recodes its 8-bit multiplier operand into radix-4 Booth digits. It then reduces the selected partial products with a tree of 4:2 compressors and resolves the last carry-save pair with a Kogge-Stone prefix adder.

In wide mode, both sub-multipliers see the full A operand:

- one multiplies A by the low byte of B, treating that byte as unsigned;
- the other multiplies A by the high byte of B, which carries the sign.

Their results are extended according to their signedness, and the high result is weighted by 256 before a final prefix addition. In dual mode, each sub-multiplier is fed one byte pair and its low 16 result bits are placed side by side on the output.

Top module: `simd_booth_mul`

## Requirements
- R1: With dual_i=0 and sgn_i=1, prod_o equals the 32-bit two's-complement product of a_i and b_i, both read as signed 16-bit values.
- R2: With dual_i=0 and sgn_i=0, prod_o equals the 32-bit product of a_i and b_i, both read as unsigned.
- R3: With dual_i=1, prod_o[15:0] equals a_i[7:0] times b_i[7:0] as a 16-bit result. The bytes are signed when sgn_i=1 and unsigned when sgn_i=0.
- R4: With dual_i=1, prod_o[31:16] equals a_i[15:8] times b_i[15:8] as a 16-bit result, with the same signedness rule as R3.
- R5: In dual mode the two halves are independent. Changing a_i[7:0] or b_i[7:0] leaves prod_o[31:16] unchanged, and changing the upper bytes leaves prod_o[15:0] unchanged.
- R6: Extreme operands produce exact results:
  - signed 0x8000 x 0x8000 gives 0x40000000;
  - unsigned 0xFFFF x 0xFFFF gives 0xFFFE0001;
  - signed lanes 0x80 x 0x80 give 0x4000;
  - unsigned lanes 0xFF x 0xFF give 0xFE01.
- R7: A zero operand gives a zero result in every mode: a_i=0 or b_i=0 forces prod_o to 0 (in dual mode, per lane).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Multiplicand; in dual mode two bytes, one per lane |
| b_i | input | 16 | Multiplier; in dual mode two bytes, one per lane |
| dual_i | input | 1 | 0: one 16x16 product; 1: two 8x8 products |
| sgn_i | input | 1 | 1: two's-complement operands; 0: unsigned |
| prod_o | output | 32 | Product; in dual mode lane 1 in bits 31:16, lane 0 in bits 15:0 |

## Verification
In dual mode both lane products are formed in the same evaluation by the two sub-multipliers. A fault in byte steering or in the sign extension of one lane could therefore leak into the other.

The bench provokes this by sweeping every byte pair of the low lane in both sign modes. At the same time it drives the high lane with a different byte pair derived from the same counter, so every cycle exercises two unrelated products. Each half is judged separately against a behavioural byte product, and a further test holds the high bytes fixed while the low bytes change to confirm that the upper half does not move.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    MODE_WIDE = 1'b0,
    MODE_DUAL = 1'b1
  } smul_mode_e;
endpackage

// File: rtl/smul_ks_adder.sv
module smul_ks_adder #(
  parameter int W = 24
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  localparam int L = $clog2(W);

  logic [W-1:0] g [0:L];
  logic [W-1:0] p [0:L];

  assign g[0] = x_i & y_i;
  assign p[0] = x_i ^ y_i;

  for (genvar l = 0; l < L; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_op
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][i-D]);
        assign p[l+1][i] = p[l][i] & p[l][i-D];
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  // carry into bit i is the group generate of bits i-1..0
  assign s_o = p[0] ^ {g[L][W-2:0], 1'b0};
endmodule

// File: rtl/smul_booth_row.sv
module smul_booth_row #(
  parameter int MW = 17,
  parameter int PW = 24
) (
  input  logic [MW-1:0] mcx_i,
  input  logic [2:0]    grp_i,
  output logic [PW-1:0] row_o,
  output logic          neg_o
);
  logic          one, two, neg;
  logic [PW-1:0] mx1, sel;

  assign mx1 = {{(PW-MW){mcx_i[MW-1]}}, mcx_i};
  assign one = grp_i[0] ^ grp_i[1];
  assign two = (grp_i == 3'b011) | (grp_i == 3'b100);
  assign neg = grp_i[2] & ~(grp_i[1] & grp_i[0]);

  always_comb begin
    if (one)      sel = mx1;
    else if (two) sel = mx1 << 1;
    else          sel = '0;
  end

  // negate as invert here; the +1 travels on neg_o into the tree
  assign row_o = neg ? ~sel : sel;
  assign neg_o = neg;
endmodule

// File: rtl/smul_c42.sv
module smul_c42 #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] s1, k1;

  assign s1  = a_i ^ b_i ^ c_i;
  assign k1  = {((a_i[W-2:0] & b_i[W-2:0]) | (a_i[W-2:0] & c_i[W-2:0]) |
                 (b_i[W-2:0] & c_i[W-2:0])), 1'b0};
  assign s_o = s1 ^ k1 ^ d_i;
  assign c_o = {((s1[W-2:0] & k1[W-2:0]) | (s1[W-2:0] & d_i[W-2:0]) |
                 (k1[W-2:0] & d_i[W-2:0])), 1'b0};
endmodule

// File: rtl/smul_sub_mul.sv
module smul_sub_mul #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic [AW-1:0]    mc_i,
  input  logic             mc_sgn_i,
  input  logic [BW-1:0]    mr_i,
  input  logic             mr_sgn_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int MW   = AW + 1;
  localparam int PW   = AW + BW;
  localparam int ND   = BW / 2 + 1;
  localparam int NR   = ND + 1;
  localparam int NRP  = NR + (NR % 2);
  localparam int NC   = NRP / 2 - 1;
  localparam int XW   = 2 * ND + 1;

  logic [MW-1:0] mcx;
  logic [XW-1:0] mrx;
  logic [PW-1:0] rows [0:NRP-1];
  logic [PW-1:0] corr;
  logic [ND-1:0] negs;

  assign mcx = {mc_sgn_i & mc_i[AW-1], mc_i};
  // extension by sign or zero, plus the implicit zero below bit 0
  assign mrx = {{(XW-BW-1){mr_sgn_i & mr_i[BW-1]}}, mr_i, 1'b0};

  for (genvar k = 0; k < ND; k++) begin : g_pp
    logic [PW-1:0] raw;
    smul_booth_row #(.MW(MW), .PW(PW)) u_row (
      .mcx_i(mcx),
      .grp_i(mrx[2*k+2 -: 3]),
      .row_o(raw),
      .neg_o(negs[k])
    );
    assign rows[k] = raw << (2 * k);
  end

  always_comb begin
    corr = '0;
    for (int k = 0; k < ND; k++) corr[2*k] = negs[k];
  end
  assign rows[ND] = corr;

  if (NRP > NR) begin : g_pad
    assign rows[NR] = '0;
  end

  for (genvar k = 0; k < NC; k++) begin : g_tree
    logic [PW-1:0] s, c;
    if (k == 0) begin : g_first
      smul_c42 #(.W(PW)) u_c42 (
        .a_i(rows[0]), .b_i(rows[1]), .c_i(rows[2]), .d_i(rows[3]),
        .s_o(s), .c_o(c)
      );
    end else begin : g_next
      smul_c42 #(.W(PW)) u_c42 (
        .a_i(g_tree[k-1].s), .b_i(g_tree[k-1].c),
        .c_i(rows[2*k+2]), .d_i(rows[2*k+3]),
        .s_o(s), .c_o(c)
      );
    end
  end

  smul_ks_adder #(.W(PW)) u_cpa (
    .x_i(g_tree[NC-1].s),
    .y_i(g_tree[NC-1].c),
    .s_o(p_o)
  );
endmodule

// File: rtl/simd_booth_mul.sv
module simd_booth_mul
  import smul_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] a_i,
  input  logic [2*LANE_W-1:0] b_i,
  input  logic                dual_i,
  input  logic                sgn_i,
  output logic [4*LANE_W-1:0] prod_o
);
  localparam int W  = 2 * LANE_W;
  localparam int PW = W + LANE_W;
  localparam int RW = 2 * W;

  smul_mode_e    mode;
  logic [W-1:0]  mc0, mc1;
  logic [LANE_W-1:0] mr0, mr1;
  logic          mc0_s, mc1_s, mr0_s, mr1_s;
  logic [PW-1:0] p0, p1;
  logic [RW-1:0] e0, e1, wide;

  assign mode = smul_mode_e'(dual_i);

  always_comb begin
    mr0   = b_i[LANE_W-1:0];
    mr1   = b_i[W-1:LANE_W];
    mr1_s = sgn_i;
    mc0_s = sgn_i;
    mc1_s = sgn_i;
    if (mode == MODE_DUAL) begin
      mc0   = {{LANE_W{sgn_i & a_i[LANE_W-1]}}, a_i[LANE_W-1:0]};
      mc1   = {{LANE_W{sgn_i & a_i[W-1]}}, a_i[W-1:LANE_W]};
      mr0_s = sgn_i;
    end else begin
      mc0   = a_i;
      mc1   = a_i;
      mr0_s = 1'b0;  // low byte of B carries no sign in wide mode
    end
  end

  smul_sub_mul #(.AW(W), .BW(LANE_W)) u_sub0 (
    .mc_i(mc0), .mc_sgn_i(mc0_s), .mr_i(mr0), .mr_sgn_i(mr0_s), .p_o(p0)
  );
  smul_sub_mul #(.AW(W), .BW(LANE_W)) u_sub1 (
    .mc_i(mc1), .mc_sgn_i(mc1_s), .mr_i(mr1), .mr_sgn_i(mr1_s), .p_o(p1)
  );

  // sign preprocessing: low partial is signed only when A is signed
  assign e0 = {{(RW-PW){mc0_s & p0[PW-1]}}, p0};
  assign e1 = {p1, {LANE_W{1'b0}}};

  smul_ks_adder #(.W(RW)) u_join (
    .x_i(e1), .y_i(e0), .s_o(wide)
  );

  assign prod_o = (mode == MODE_DUAL) ? {p1[W-1:0], p0[W-1:0]} : wide;
endmodule

// File: rtl/simd_booth_mul_chk.sv
module simd_booth_mul_chk #(
  parameter int LANE_W = 8
) (
  input logic [2*LANE_W-1:0] a_i,
  input logic [2*LANE_W-1:0] b_i,
  input logic                dual_i,
  input logic                sgn_i,
  input logic [4*LANE_W-1:0] prod_o
);
  localparam int W = 2 * LANE_W;

  logic signed [2*W-1:0] ref_s;
  logic [2*W-1:0]        ref_u;
  logic [W-1:0]          lo_ref, hi_ref;

  always_comb begin
    ref_s = $signed(a_i) * $signed(b_i);
    ref_u = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    if (sgn_i) begin
      lo_ref = W'($signed(a_i[LANE_W-1:0]) * $signed(b_i[LANE_W-1:0]));
      hi_ref = W'($signed(a_i[W-1:LANE_W]) * $signed(b_i[W-1:LANE_W]));
    end else begin
      lo_ref = W'({{LANE_W{1'b0}}, a_i[LANE_W-1:0]} * {{LANE_W{1'b0}}, b_i[LANE_W-1:0]});
      hi_ref = W'({{LANE_W{1'b0}}, a_i[W-1:LANE_W]} * {{LANE_W{1'b0}}, b_i[W-1:LANE_W]});
    end
  end

  always_comb begin
    if (!dual_i && sgn_i)
      a_r1_wide_signed: assert (prod_o == ref_s) else $error("R1 wide signed mismatch");
    if (!dual_i && !sgn_i)
      a_r2_wide_unsigned: assert (prod_o == ref_u) else $error("R2 wide unsigned mismatch");
    if (dual_i)
      a_r3_lane_lo: assert (prod_o[W-1:0] == lo_ref) else $error("R3 low lane mismatch");
    if (dual_i)
      a_r4_lane_hi: assert (prod_o[2*W-1:W] == hi_ref) else $error("R4 high lane mismatch");
    if (!dual_i && (a_i == '0 || b_i == '0))
      a_r7_zero_operand: assert (prod_o == '0) else $error("R7 zero operand");
  end
endmodule

bind simd_booth_mul simd_booth_mul_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/simd_booth_mul_bench.sv
module simd_booth_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        dual, sgn;
  logic [31:0] prod;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_booth_mul u_simd_booth_mul (
    .a_i(a), .b_i(b), .dual_i(dual), .sgn_i(sgn), .prod_o(prod)
  );

  function automatic logic [31:0] ref_wide(logic [15:0] x, logic [15:0] y, logic s);
    longint r;
    if (s) r = longint'($signed(x)) * longint'($signed(y));
    else   r = longint'({1'b0, x}) * longint'({1'b0, y});
    return r[31:0];
  endfunction

  function automatic logic [15:0] ref_lane(logic [7:0] x, logic [7:0] y, logic s);
    int r;
    if (s) r = int'($signed(x)) * int'($signed(y));
    else   r = int'({1'b0, x}) * int'({1'b0, y});
    return r[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] x, logic [15:0] y, logic d, logic s);
    @(posedge clk);
    a = x; b = y; dual = d; sgn = s;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R7 idle zero inputs", prod, 32'h0);
  endtask

  task automatic t_zero();
    apply(16'h0000, 16'hBEEF, 1'b0, 1'b1); check("R7 a zero signed", prod, 32'h0);
    apply(16'h1234, 16'h0000, 1'b0, 1'b0); check("R7 b zero unsigned", prod, 32'h0);
    apply(16'hA500, 16'h00C3, 1'b1, 1'b1); check("R7 dual both lanes zero", prod, 32'h0);
  endtask

  task automatic t_corners();
    apply(16'h8000, 16'h8000, 1'b0, 1'b1); check("R6 R1 min*min", prod, 32'h40000000);
    apply(16'h8000, 16'h7FFF, 1'b0, 1'b1); check("R6 R1 min*max", prod, 32'hC0008000);
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0); check("R6 R2 max*max", prod, 32'hFFFE0001);
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1); check("R1 -1*-1", prod, 32'h00000001);
    apply(16'h8080, 16'h8080, 1'b1, 1'b1); check("R6 R3 R4 lanes min*min", prod, 32'h40004000);
    apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0); check("R6 R3 R4 lanes max*max", prod, 32'hFE01FE01);
    apply(16'h00FF, 16'h0180, 1'b0, 1'b1); check("R1 unsigned low byte of b", prod, 32'h00017E80);
  endtask

  task automatic t_rand_wide(logic s);
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = 16'($urandom);
      apply(x, y, 1'b0, s);
      check(s ? "R1 random wide" : "R2 random wide", prod, ref_wide(x, y, s));
    end
  endtask

  task automatic t_dual_sweep(logic s);
    for (int i = 0; i < 65536; i++) begin
      logic [7:0] al, bl, ah, bh;
      al = i[7:0];
      bl = i[15:8];
      ah = i[15:8] ^ 8'h5A;
      bh = i[7:0] + 8'd37;
      apply({ah, al}, {bh, bl}, 1'b1, s);
      check("R3 low lane", {16'h0, prod[15:0]}, {16'h0, ref_lane(al, bl, s)});
      check("R4 high lane", {16'h0, prod[31:16]}, {16'h0, ref_lane(ah, bh, s)});
    end
  endtask

  task automatic t_lane_indep();
    logic [15:0] hi_exp, lo_exp;
    hi_exp = ref_lane(8'h9C, 8'hE3, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] x, y;
      x = 8'(i * 37 + 3);
      y = 8'(255 - i * 29);
      apply({8'h9C, x}, {8'hE3, y}, 1'b1, 1'b1);
      check("R5 high half steady", {16'h0, prod[31:16]}, {16'h0, hi_exp});
    end
    lo_exp = ref_lane(8'h7F, 8'h81, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] x;
      x = 8'(i * 53 + 1);
      apply({x, 8'h7F}, {~x, 8'h81}, 1'b1, 1'b0);
      check("R5 low half steady", {16'h0, prod[15:0]}, {16'h0, lo_exp});
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    a = '0; b = '0; dual = 1'b0; sgn = 1'b0;
    t_reset_state();
    t_zero();
    t_corners();
    t_rand_wide(1'b1);
    t_rand_wide(1'b0);
    t_lane_indep();
    t_dual_sweep(1'b1);
    t_dual_sweep(1'b0);
    finish_run();
  end
endmodule